// File: doc/BRIEF.md
# Flagless Three-Operand Shift Unit

This block performs the three count-from-register shifts of a processor integer pipe: a logical left shift, an arithmetic right shift and a logical right shift. None of them reads or writes condition flags, so the unit has no flag ports. A 2-bit selector from the prefix decides which shift runs. The operand width is 64 bits only when the core is in 64-bit mode and the wide-operand prefix bit is set. In every other case the width is 32 bits. The shift amount is a register value that the operand fetch stage supplies. The unit masks it to the width of the selected operand size.

The same prefix carries the index of the count register as a 4-bit field in inverted form. The unit returns the true index next to the result so that the surrounding pipeline can track it. Every output is registered, with one cycle of latency from an accepted input. There is no immediate operand. Reset is synchronous and active high.

Top module: `flagless_shift_unit`

## Requirements
- R1: Selector 2'b01 gives a logical left shift, 2'b10 gives an arithmetic right shift and 2'b11 gives a logical right shift of `src_val` by the masked count.
- R2: Selector 2'b00 is invalid. It gives `result` = 0 with `bad_sel` = 1. Every valid selector gives `bad_sel` = 0.
- R3: `size64` is 1 exactly when `mode64` = 1 and `wide_w` = 1. Otherwise the operand size is 32 bits.
- R4: The count is `cnt_raw` masked to its low 5 bits for 32-bit operands and to its low 6 bits for 64-bit operands. Higher count bits have no effect.
- R5: For 32-bit operands, only `src_val[31:0]` is used and `result[63:32]` is 0.
- R6: The arithmetic right shift fills vacated bits with the sign bit of the selected size: bit 31 for 32-bit operands and bit 63 for 64-bit operands.
- R7: `cnt_reg_idx` is the bitwise inverse of the 4-bit `sel_vvvv`.
- R8: Each output is registered. `out_valid` is 1 in the cycle after an input with `in_valid` = 1 and 0 otherwise. The data outputs keep their values while `in_valid` = 0.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| sel_pp | input | 2 | Shift selector (01 left, 10 arithmetic right, 11 logical right) |
| wide_w | input | 1 | Wide-operand prefix bit |
| mode64 | input | 1 | Core is in 64-bit mode |
| sel_vvvv | input | 4 | Inverted count register index |
| src_val | input | 64 | Value to shift |
| cnt_raw | input | 64 | Unmasked count register value |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Shifted value |
| size64 | output | 1 | Result is 64 bits wide |
| bad_sel | output | 1 | Selector was invalid |
| cnt_reg_idx | output | 4 | Decoded count register index |

## Verification
Two functions act on the same shift in one cycle: count masking and sign fill. An arithmetic right shift of a 32-bit operand with a negative bit 31 and a raw count such as 0x3F must use only the low 5 bits of the count. It must also fill the vacated bits from bit 31 and leave the upper half zero. The bench provokes this with negative 32-bit and 64-bit operands, using counts at and above the masked maximum. It judges the result against a bit-by-bit reference shift. A second coincidence occurs when the size decode and the invalid selector meet in one request. The bench checks that the zero result and the error indication appear together.

// File: rtl/shx_pkg.sv
package shx_pkg;
  // Encoding equals the selector bits; the order is fixed by the decoder.
  typedef enum logic [1:0] {
    SHX_NONE = 2'b00,
    SHX_SHL  = 2'b01,
    SHX_SAR  = 2'b10,
    SHX_SHR  = 2'b11
  } shx_op_e;
endpackage

// File: rtl/shx_decode.sv
module shx_decode #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [1:0]        sel_pp,
  input  logic              wide_w,
  input  logic              mode64,
  input  logic [IDX_W-1:0]  sel_vvvv,
  input  logic [DATA_W-1:0] cnt_raw,
  output shx_pkg::shx_op_e  op,
  output logic              is64,
  output logic              bad,
  output logic [IDX_W-1:0]  idx,
  output logic [CNT_W-1:0]  cnt_m
);
  logic [CNT_W-1:0] mask;

  always_comb begin
    op   = shx_pkg::shx_op_e'(sel_pp);
    bad  = (op == shx_pkg::SHX_NONE);
    is64 = mode64 & wide_w;
    idx  = ~sel_vvvv;
    // Narrow size drops the top count bit.
    mask = is64 ? {CNT_W{1'b1}} : {1'b0, {(CNT_W-1){1'b1}}};
    cnt_m = cnt_raw[CNT_W-1:0] & mask;
  end
endmodule

// File: rtl/shx_core.sv
module shx_core #(
  parameter int DATA_W = 64,
  localparam int CNT_W  = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input  shx_pkg::shx_op_e  op,
  input  logic              is64,
  input  logic [DATA_W-1:0] val,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] ext_s, ext_z, raw;

  always_comb begin
    ext_z = is64 ? val : {{HALF_W{1'b0}}, val[HALF_W-1:0]};
    ext_s = is64 ? val : {{HALF_W{val[HALF_W-1]}}, val[HALF_W-1:0]};
    unique case (op)
      shx_pkg::SHX_SHL: raw = ext_z << cnt;
      shx_pkg::SHX_SAR: raw = DATA_W'($signed(ext_s) >>> cnt);
      shx_pkg::SHX_SHR: raw = ext_z >> cnt;
      default:          raw = '0;
    endcase
    res = is64 ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
  end
endmodule

// File: rtl/flagless_shift_unit.sv
module flagless_shift_unit #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        sel_pp,
  input  logic              wide_w,
  input  logic              mode64,
  input  logic [IDX_W-1:0]  sel_vvvv,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] cnt_raw,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              size64,
  output logic              bad_sel,
  output logic [IDX_W-1:0]  cnt_reg_idx
);
  shx_pkg::shx_op_e  op;
  logic              is64, bad;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt_m;
  logic [DATA_W-1:0] res_c;

  shx_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .sel_pp(sel_pp), .wide_w(wide_w), .mode64(mode64),
    .sel_vvvv(sel_vvvv), .cnt_raw(cnt_raw),
    .op(op), .is64(is64), .bad(bad), .idx(idx), .cnt_m(cnt_m)
  );

  shx_core #(.DATA_W(DATA_W)) u_core (
    .op(op), .is64(is64), .val(src_val), .cnt(cnt_m), .res(res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      size64      <= 1'b0;
      bad_sel     <= 1'b0;
      cnt_reg_idx <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result      <= res_c;
        size64      <= is64;
        bad_sel     <= bad;
        cnt_reg_idx <= idx;
      end
    end
  end
endmodule

// File: rtl/flagless_shift_unit_chk.sv
module flagless_shift_unit_chk #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        sel_pp,
  input logic              wide_w,
  input logic              mode64,
  input logic [IDX_W-1:0]  sel_vvvv,
  input logic [DATA_W-1:0] src_val,
  input logic [DATA_W-1:0] cnt_raw,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              size64,
  input logic              bad_sel,
  input logic [IDX_W-1:0]  cnt_reg_idx
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W);

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bad_sel) |-> (result == '0)); // R2

  AST_SIZE_DECODE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (size64 == $past(mode64 && wide_w))); // R3

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !size64) |-> (result[DATA_W-1:HALF_W] == '0)); // R5

  AST_IDX_INVERT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (cnt_reg_idx == ~$past(sel_vvvv))); // R7

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result))); // R8

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_pp != 2'b00 && cnt_raw[CNT_W-2:0] == '0 && !(mode64 && wide_w && cnt_raw[CNT_W-1]))
      |=> (result == (size64 ? $past(src_val) : {{HALF_W{1'b0}}, $past(src_val[HALF_W-1:0])}))); // R4
endmodule

bind flagless_shift_unit flagless_shift_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_flagless_shift_unit.sv
`timescale 1ns/1ps
module tb_flagless_shift_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  sel_pp = 2'b00;
  logic        wide_w = 1'b0;
  logic        mode64 = 1'b0;
  logic [3:0]  sel_vvvv = 4'h0;
  logic [63:0] src_val = '0;
  logic [63:0] cnt_raw = '0;
  logic        out_valid, size64, bad_sel;
  logic [63:0] result;
  logic [3:0]  cnt_reg_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flagless_shift_unit dut (.*);

  function automatic logic [63:0] ref_shift(input logic [1:0] pp, input logic s64,
                                            input logic [63:0] v_in, input logic [63:0] c_in);
    logic [63:0] v;
    int n;
    n = s64 ? int'(c_in[5:0]) : int'(c_in[4:0]);
    v = s64 ? v_in : {32'h0, v_in[31:0]};
    if (pp == 2'b00) return 64'h0;
    for (int i = 0; i < n; i++) begin
      case (pp)
        2'b01: v = {v[62:0], 1'b0};
        2'b11: v = {1'b0, v[63:1]};
        default: v = s64 ? {v[63], v[63:1]} : {32'h0, v[31], v[31:1]};
      endcase
    end
    if (!s64) v[63:32] = 32'h0;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge, check at the next falling edge.
  task automatic apply(input string req, input logic [1:0] pp, input logic w, input logic m,
                       input logic [63:0] s, input logic [63:0] c, input logic [3:0] vv);
    logic s64;
    s64 = w & m;
    in_valid = 1'b1; sel_pp = pp; wide_w = w; mode64 = m;
    src_val = s; cnt_raw = c; sel_vvvv = vv;
    @(negedge clk);
    check({req, " result"}, result, ref_shift(pp, s64, s, c));
    check("R3 size", {63'h0, size64}, {63'h0, s64});
    check("R2 bad_sel", {63'h0, bad_sel}, {63'h0, pp == 2'b00});
    check("R7 idx", {60'h0, cnt_reg_idx}, {60'h0, ~vv});
    check("R8 out_valid", {63'h0, out_valid}, 64'h1);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 out_valid", {63'h0, out_valid}, 64'h0);
    check("R9 result", result, 64'h0);
    check("R9 size64", {63'h0, size64}, 64'h0);
    check("R9 bad_sel", {63'h0, bad_sel}, 64'h0);
    check("R9 idx", {60'h0, cnt_reg_idx}, 64'h0);
  endtask

  task automatic t_ops;
    logic [63:0] pat [3];
    logic [63:0] cnts [6];
    pat[0] = 64'h8123_4567_89AB_CDEF;
    pat[1] = 64'h0F00_FF00_7654_3210;
    pat[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    cnts[0] = 64'd0; cnts[1] = 64'd1; cnts[2] = 64'd31;
    cnts[3] = 64'd63; cnts[4] = 64'h40; cnts[5] = 64'hFFFF_FFFF_FFFF_FFE5;
    for (int op = 1; op < 4; op++)
      for (int sz = 0; sz < 2; sz++)
        for (int p = 0; p < 3; p++)
          for (int k = 0; k < 6; k++)
            apply(op == 2 ? "R6 R4 sar" : "R1 R4 R5 shift", 2'(op), sz[0], 1'b1,
                  pat[p], cnts[k], 4'(k + p));
  endtask

  task automatic t_sign_corner;
    apply("R6 sar32 neg", 2'b10, 1'b0, 1'b1, 64'h0000_0000_8000_0000, 64'h3F, 4'h3);
    apply("R6 sar32 hi ignored", 2'b10, 1'b0, 1'b0, 64'h8000_0000_7000_0000, 64'd4, 4'h9);
    apply("R6 sar64 neg", 2'b10, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd63, 4'hE);
    apply("R5 shl32 overflow", 2'b01, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8, 4'h1);
  endtask

  task automatic t_invalid;
    apply("R2 invalid 64", 2'b00, 1'b1, 1'b1, 64'hDEAD_BEEF_0123_4567, 64'd3, 4'h5);
    apply("R2 invalid 32", 2'b00, 1'b0, 1'b1, 64'h1234_5678, 64'd0, 4'hA);
  endtask

  task automatic t_size;
    apply("R3 w no mode", 2'b11, 1'b1, 1'b0, 64'hF000_0000_F000_0000, 64'd36, 4'h0);
    apply("R3 mode no w", 2'b11, 1'b0, 1'b1, 64'hF000_0000_F000_0000, 64'd36, 4'hF);
  endtask

  task automatic t_hold;
    logic [63:0] r_prev;
    apply("R8 pre", 2'b01, 1'b1, 1'b1, 64'h1, 64'd5, 4'h6);
    r_prev = result;
    in_valid = 1'b0; sel_pp = 2'b11; src_val = 64'hFFFF; cnt_raw = 64'd2; sel_vvvv = 4'h0;
    @(negedge clk);
    check("R8 idle valid", {63'h0, out_valid}, 64'h0);
    check("R8 idle result", result, r_prev);
    check("R8 idle idx", {60'h0, cnt_reg_idx}, {60'h0, ~4'h6});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ops();
        t_sign_corner();
        t_invalid();
        t_size();
        t_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule